// File: doc/BRIEF.md
# Multi-Mode Capture Timer/Counter

A pair of 8-bit counters that act as one 16-bit block or as two 8-bit halves. A 2-bit mode field selects one of four arrangements. In the first, two prescaled 8-bit timers run side by side. In the second, a prescaled 8-bit timer sits in the low half and an 8-bit event counter in the high half. In the third, the halves cascade into one prescaled 16-bit timer. In the fourth, they form a 16-bit event counter with no prescaler. Each counter has a match value. When the counter is advanced while it equals that value, it returns to zero and raises a sticky flag.

The timer clock is the system clock gated by a one-cycle `tick` enable. External events and capture triggers come in on asynchronous pins. Each pin passes through a two-stage synchroniser and then a rising-edge detector. A capture edge freezes the counters into two 8-bit capture registers, which the block drives continuously. Software writes the mode, the prescaler reload value and the two match values through a simple write port, and clears flags by writing ones.

The mode register acts as the state of the block. Its states are MODE_DUAL8 (0), MODE_TMR_EVT (1), MODE_TMR16 (2) and MODE_EVT16 (3). A write to the mode address is the only transition. It moves the block from any state to the state written, and it zeroes both counters and both prescalers.

Top module: `capture_timer`

## Requirements
- R1: After reset, both flags and both capture registers are 0, the mode is MODE_DUAL8, the prescaler reload value is 0 and both match values are 8'hFF.
- R2: Register writes use `wr_addr`. Address 0 sets the mode from `wr_data[1:0]`. Address 1 sets the prescaler reload value. Address 2 sets the low match value and address 3 the high match value. Address 4 clears flags, with bit 0 clearing the low flag and bit 1 the high flag. Writes to addresses 5 to 7 change nothing.
- R3: A prescaler counts cycles in which `tick` is 1. It produces one advance for every reload+1 ticks and holds its count while `tick` is 0.
- R4: In mode 0, each half is an 8-bit timer advanced by its own prescaler. Both prescalers use the shared reload value.
- R5: In mode 1, the low half is a prescaled 8-bit timer and the high half counts synchronised rising edges of `ev_in`.
- R6: In mode 2, the halves form one 16-bit timer advanced by the prescaler, with the high half as the upper byte. The low half carries into the high half.
- R7: In mode 3, the halves form a 16-bit counter of `ev_in` rising edges, and `tick` has no effect on it.
- R8: An advance applied while a counter equals its match value sets that counter to zero and sets its flag. In modes 2 and 3, the 16-bit value is compared with {high match, low match}, and a match sets only `hi_hit`. `lo_hit` is never set in these modes.
- R9: Flags stay set until cleared through address 4. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R10: `ev_in` and `cap_in` each pass through two synchronising flip-flops and a rising-edge detector. A rise first sampled at clock edge k acts at clock edge k+2.
- R11: A detected capture edge copies the counter values from before that cycle's update into `cap_lo` and `cap_hi`, so an advance in the same cycle does not alter what is captured. Without a capture edge, both capture registers hold their values.
- R12: A mode write zeroes both counters and both prescalers, and no advance takes effect in that cycle. Flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable for the prescalers |
| ev_in | input | 1 | Asynchronous external event input |
| cap_in | input | 1 | Asynchronous capture trigger |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| lo_hit | output | 1 | Sticky low-half match flag |
| hi_hit | output | 1 | Sticky high-half (or 16-bit) match flag |
| cap_lo | output | 8 | Captured low byte |
| cap_hi | output | 8 | Captured high byte |

## Verification
The bench drives an event edge and a capture edge in the same cycle. A design that captured after the increment would report 1 where 0 is expected. A 16-bit cascade test wraps at 0x0110. A design that compared only one byte, or that raised the low flag in a wide mode, would show the wrong flag pattern. Other directed cases check the prescaler ratio through a capture, a flag clear issued while the other flag stays set, a mode write in the middle of a count, and writes to unused addresses. A long stretch of random writes and pin activity is then compared cycle by cycle against a model written from the requirements.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;
    typedef enum logic [1:0] {
        MODE_DUAL8   = 2'd0,
        MODE_TMR_EVT = 2'd1,
        MODE_TMR16   = 2'd2,
        MODE_EVT16   = 2'd3
    } tmr_mode_e;

    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_LOMAT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_HIMAT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLRFLG = 3'd4;
endpackage

// File: rtl/ct_sync_edge.sv
module ct_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R10: a detected edge lasts a single cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [PRE_W-1:0] reload,
    output logic             adv
);
    logic [PRE_W-1:0] cnt_q;

    assign adv = tick && (cnt_q == reload);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (tick) cnt_q <= adv ? '0 : cnt_q + 1'b1;
    end

    // R3: count is frozen while tick is low
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q));
    // R12: clear empties the prescaler
    a_r12_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import cap_tmr_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = (HALF_W > PRE_W) ? HALF_W : PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ev_in,
    input  logic              cap_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              lo_hit,
    output logic              hi_hit,
    output logic [HALF_W-1:0] cap_lo,
    output logic [HALF_W-1:0] cap_hi
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int N_PRE  = 2;

    tmr_mode_e         mode_q;
    logic [PRE_W-1:0]  reload_q;
    logic [HALF_W-1:0] lo_match_q, hi_match_q;
    logic [HALF_W-1:0] lo_cnt, hi_cnt, lo_nxt, hi_nxt;
    logic [HALF_W-1:0] cap_lo_q, cap_hi_q;
    logic              lo_hit_q, hi_hit_q;
    logic              lo_set, hi_set, lo_adv, hi_adv, wide;
    logic              ev_pulse, cap_pulse;
    logic [N_PRE-1:0]  pre_adv;

    logic mode_wr, clr_wr;
    assign mode_wr = wr_en && (wr_addr == A_MODE);
    assign clr_wr  = wr_en && (wr_addr == A_CLRFLG);

    ct_sync_edge #(.STAGES(SYNC_STAGES)) u_ev_sync (
        .clk(clk), .rst_n(rst_n), .din(ev_in), .rise(ev_pulse));
    ct_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_pulse));

    for (genvar g = 0; g < N_PRE; g++) begin : g_pre
        ct_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .clr(mode_wr), .tick(tick),
            .reload(reload_q), .adv(pre_adv[g]));
    end

    // configuration registers; the mode register is the block state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_DUAL8;
            reload_q   <= '0;
            lo_match_q <= '1;
            hi_match_q <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_MODE:   mode_q     <= tmr_mode_e'(wr_data[1:0]);
                A_RELOAD: reload_q   <= wr_data[PRE_W-1:0];
                A_LOMAT:  lo_match_q <= wr_data[HALF_W-1:0];
                A_HIMAT:  hi_match_q <= wr_data[HALF_W-1:0];
                default:  ;
            endcase
        end
    end

    // advance sources per mode
    always_comb begin
        lo_adv = 1'b0;
        hi_adv = 1'b0;
        wide   = 1'b0;
        unique case (mode_q)
            MODE_DUAL8:   begin lo_adv = pre_adv[0]; hi_adv = pre_adv[1]; end
            MODE_TMR_EVT: begin lo_adv = pre_adv[0]; hi_adv = ev_pulse;   end
            MODE_TMR16:   begin lo_adv = pre_adv[0]; wide = 1'b1;         end
            MODE_EVT16:   begin lo_adv = ev_pulse;   wide = 1'b1;         end
        endcase
    end

    // counter next-state and match detection
    always_comb begin
        lo_nxt = lo_cnt;
        hi_nxt = hi_cnt;
        lo_set = 1'b0;
        hi_set = 1'b0;
        if (wide) begin
            if (lo_adv) begin
                if ({hi_cnt, lo_cnt} == {hi_match_q, lo_match_q}) begin
                    {hi_nxt, lo_nxt} = '0;
                    hi_set = 1'b1;
                end else begin
                    {hi_nxt, lo_nxt} = {hi_cnt, lo_cnt} + FULL_W'(1);
                end
            end
        end else begin
            if (lo_adv) begin
                if (lo_cnt == lo_match_q) begin lo_nxt = '0; lo_set = 1'b1; end
                else                            lo_nxt = lo_cnt + 1'b1;
            end
            if (hi_adv) begin
                if (hi_cnt == hi_match_q) begin hi_nxt = '0; hi_set = 1'b1; end
                else                            hi_nxt = hi_cnt + 1'b1;
            end
        end
    end

    // state-holding outputs: counters, flags, captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt   <= '0;
            hi_cnt   <= '0;
            lo_hit_q <= 1'b0;
            hi_hit_q <= 1'b0;
            cap_lo_q <= '0;
            cap_hi_q <= '0;
        end else begin
            if (mode_wr) begin
                lo_cnt <= '0;
                hi_cnt <= '0;
            end else begin
                lo_cnt <= lo_nxt;
                hi_cnt <= hi_nxt;
            end
            lo_hit_q <= (lo_set && !mode_wr) | (lo_hit_q & ~(clr_wr & wr_data[0]));
            hi_hit_q <= (hi_set && !mode_wr) | (hi_hit_q & ~(clr_wr & wr_data[1]));
            if (cap_pulse) begin
                cap_lo_q <= lo_cnt;
                cap_hi_q <= hi_cnt;
            end
        end
    end

    assign lo_hit = lo_hit_q;
    assign hi_hit = hi_hit_q;
    assign cap_lo = cap_lo_q;
    assign cap_hi = cap_hi_q;

    // R9: a set flag survives unless its clear bit is written
    a_r9_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_hit_q && !(clr_wr && wr_data[0])) |=> lo_hit_q);
    a_r9_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_hit_q && !(clr_wr && wr_data[1])) |=> hi_hit_q);
    // R8: wide modes never raise the low flag
    a_r8_wide_no_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !lo_hit_q) |=> !lo_hit_q);
    // R12: mode write leaves both counters at zero
    a_r12_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (lo_cnt == '0 && hi_cnt == '0));
    // R11: captures only move on a capture edge
    a_r11_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> ($stable(cap_lo_q) && $stable(cap_hi_q)));
    // R7: event counter idle without an event
    a_r7_evt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_EVT16 && !ev_pulse && !mode_wr) |=> ($stable(lo_cnt) && $stable(hi_cnt)));
endmodule

// File: tb/capture_timer_tb.sv
module capture_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, ev_in = 1'b0, cap_in = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       lo_hit, hi_hit;
    logic [7:0] cap_lo, cap_hi;

    int    n_chk = 0, n_fail = 0;
    string tag = "R1";
    bit    done = 0;

    always #10 clk = ~clk;

    capture_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ev_in(ev_in), .cap_in(cap_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lo_hit(lo_hit), .hi_hit(hi_hit), .cap_lo(cap_lo), .cap_hi(cap_hi));

    // reference model built from the requirements
    logic [1:0] m_mode;
    logic [7:0] m_rel, m_lm, m_hm, m_lo, m_hi, m_p0, m_p1, m_clo, m_chi;
    logic       m_lh, m_hh, e1, e2, e3, c1, c2, c3;

    always @(posedge clk) begin : model
        logic evp, cpp, a0, a1, la, ha, wd, ls, hs;
        logic [15:0] w;
        if (!rst_n) begin
            m_mode = 0; m_rel = 0; m_lm = 8'hFF; m_hm = 8'hFF;
            m_lo = 0; m_hi = 0; m_p0 = 0; m_p1 = 0; m_clo = 0; m_chi = 0;
            m_lh = 0; m_hh = 0; {e1, e2, e3, c1, c2, c3} = '0;
        end else begin
            evp = e2 & ~e3;
            cpp = c2 & ~c3;
            if (cpp) begin m_clo = m_lo; m_chi = m_hi; end
            a0 = tick && (m_p0 == m_rel);
            a1 = tick && (m_p1 == m_rel);
            la = 0; ha = 0; wd = 0; ls = 0; hs = 0;
            case (m_mode)
                2'd0: begin la = a0; ha = a1; end
                2'd1: begin la = a0; ha = evp; end
                2'd2: begin la = a0; wd = 1; end
                default: begin la = evp; wd = 1; end
            endcase
            if (wr_en && wr_addr == 3'd0) begin
                m_mode = wr_data[1:0];
                m_lo = 0; m_hi = 0; m_p0 = 0; m_p1 = 0;
            end else begin
                if (tick) begin
                    m_p0 = a0 ? 8'd0 : m_p0 + 8'd1;
                    m_p1 = a1 ? 8'd0 : m_p1 + 8'd1;
                end
                if (wd) begin
                    if (la) begin
                        w = {m_hi, m_lo};
                        if (w == {m_hm, m_lm}) begin w = 0; hs = 1; end
                        else w = w + 16'd1;
                        {m_hi, m_lo} = w;
                    end
                end else begin
                    if (la) begin
                        if (m_lo == m_lm) begin m_lo = 0; ls = 1; end
                        else m_lo = m_lo + 8'd1;
                    end
                    if (ha) begin
                        if (m_hi == m_hm) begin m_hi = 0; hs = 1; end
                        else m_hi = m_hi + 8'd1;
                    end
                end
            end
            m_lh = ls | (m_lh & ~(wr_en && wr_addr == 3'd4 && wr_data[0]));
            m_hh = hs | (m_hh & ~(wr_en && wr_addr == 3'd4 && wr_data[1]));
            if (wr_en && wr_addr == 3'd1) m_rel = wr_data;
            if (wr_en && wr_addr == 3'd2) m_lm = wr_data;
            if (wr_en && wr_addr == 3'd3) m_hm = wr_data;
            e3 = e2; e2 = e1; e1 = ev_in;
            c3 = c2; c2 = c1; c1 = cap_in;
        end
    end

    task automatic chk(input bit ok, input string t, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(lo_hit == m_lh, tag, "lo_hit", lo_hit, m_lh);
        chk(hi_hit == m_hh, tag, "hi_hit", hi_hit, m_hh);
        chk(cap_lo == m_clo, tag, "cap_lo", cap_lo, m_clo);
        chk(cap_hi == m_chi, tag, "cap_hi", cap_hi, m_chi);
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 0;
    endtask

    task automatic ev_edge();
        ev_in = 1; cyc(3); ev_in = 0; cyc(3);
    endtask

    task automatic cap_edge();
        cap_in = 1; cyc(3); cap_in = 0; cyc(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        tag = "R1";
        chk(lo_hit == 0 && hi_hit == 0, "R1", "flags", {lo_hit, hi_hit}, 0);
        chk(cap_lo == 0 && cap_hi == 0, "R1", "captures", {cap_hi, cap_lo}, 0);
        cyc(2);

        // R3 prescaler ratio seen through a capture; R2 unused address ignored
        tag = "R3";
        wr(3'd6, 8'h00);
        wr(3'd1, 8'd3);
        wr(3'd0, 8'd0);
        tick = 1; cyc(12); tick = 0;
        cap_edge();
        chk(cap_lo == 8'd3, "R3", "cap_lo after 12 ticks", cap_lo, 3);
        chk(cap_hi == 8'd3, "R4", "cap_hi after 12 ticks", cap_hi, 3);

        // R4 dual timers with matches; R8 flags
        tag = "R4";
        wr(3'd1, 8'd2); wr(3'd2, 8'd4); wr(3'd3, 8'd6); wr(3'd0, 8'd0);
        tick = 1;
        for (int i = 0; i < 60; i++) begin
            cap_in = (i % 7) < 3;
            cyc();
        end
        tick = 0; cap_in = 0; cyc(3);
        chk(lo_hit == 1, "R8", "lo_hit mode0", lo_hit, 1);
        chk(hi_hit == 1, "R8", "hi_hit mode0", hi_hit, 1);

        // R9 selective flag clear
        tag = "R9";
        wr(3'd4, 8'h01);
        chk(lo_hit == 0, "R9", "lo_hit after clear", lo_hit, 0);
        chk(hi_hit == 1, "R9", "hi_hit kept", hi_hit, 1);
        cyc(3);
        wr(3'd4, 8'h02);
        chk(hi_hit == 0, "R9", "hi_hit after clear", hi_hit, 0);

        // R5 timer + event counter
        tag = "R5";
        wr(3'd1, 8'd1); wr(3'd2, 8'd9); wr(3'd3, 8'd3); wr(3'd0, 8'd1);
        for (int i = 0; i < 400; i++) begin
            tick = $urandom % 2; ev_in = ($urandom % 4) == 0; cap_in = ($urandom % 5) == 0;
            cyc();
        end
        tick = 0; ev_in = 0; cap_in = 0; cyc(4);

        // R6 16-bit prescaled timer, wraps at 0x0110
        tag = "R6";
        wr(3'd4, 8'h03);
        wr(3'd1, 8'd0); wr(3'd2, 8'h10); wr(3'd3, 8'h01); wr(3'd0, 8'd2);
        tick = 1; cyc(300); tick = 0;
        chk(hi_hit == 1, "R6", "hi_hit 16-bit wrap", hi_hit, 1);
        chk(lo_hit == 0, "R8", "lo_hit in wide mode", lo_hit, 0);
        cap_edge();

        // R7 16-bit event counter, tick irrelevant
        tag = "R7";
        wr(3'd2, 8'd5); wr(3'd3, 8'd0); wr(3'd0, 8'd3);
        tick = 1;
        ev_edge(); ev_edge(); ev_edge();
        cap_edge();
        chk(cap_lo == 8'd3 && cap_hi == 8'd0, "R7", "event count", {cap_hi, cap_lo}, 3);

        // R12 mode write zeroes; R11 simultaneous event and capture
        tag = "R11";
        wr(3'd0, 8'd3);
        ev_in = 1; cap_in = 1; cyc(3); ev_in = 0; cap_in = 0; cyc(3);
        chk(cap_lo == 8'd0, "R11", "capture not corrupted by increment", cap_lo, 0);
        chk(cap_hi == 8'd0, "R12", "counter zeroed by mode write", cap_hi, 0);
        // R10 latency: event edge counted exactly once two clocks after sampling
        tag = "R10";
        ev_in = 1; cyc(1);
        cap_in = 1; cyc(1); cap_in = 0; cyc(1);
        chk(cap_lo == 8'd0, "R10", "count before edge+2", cap_lo, 0);
        ev_in = 0; cyc(3);
        cap_edge();
        chk(cap_lo == 8'd2, "R10", "count after second event", cap_lo, 2);
        tick = 0;

        // random mix, every address including unused ones (R2)
        tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            tick   = $urandom % 2;
            ev_in  = ($urandom % 3) == 0;
            cap_in = ($urandom % 6) == 0;
            if (($urandom % 12) == 0) begin
                wr_en = 1; wr_addr = 3'($urandom % 8);
                wr_data = (wr_addr == 3'd2 || wr_addr == 3'd3) ? 8'($urandom % 24) : 8'($urandom % 4);
            end else begin
                wr_en = 0;
            end
            cyc();
        end
        wr_en = 0;
        cyc(5);
        finish_run();
    end
endmodule